// File: doc/BRIEF.md
# Interrupt Steering Router

This block takes interrupt requests from three kinds of requester and folds them onto a 16-line request vector of the kind a classic cascaded interrupt controller pair consumes. Add-in card slots each have four interrupt pins. Each pin carries a routing entry that either leaves it unconnected or points it at one of a small set of steerable channels. Each channel names a target line and a sensitivity. Motherboard sources each have their own enable and target line, and they supply their own sensitivity. Direct requests land on the line given by the low four bits of their index and are always edge-sensitive.

All tables are loaded and read back through an 8-bit address/data port with a write strobe. The router publishes, one clock after the requests, a registered vector of the lines being requested. Alongside it is a vector marking which of those lines are requested by a level-sensitive source. A line stays asserted for as long as any source mapped to it keeps requesting. Target values above 15, including the reset marker 0x80, park a channel or source so that it drives nothing.

The register map is as follows. Routing entry for slot `s`, pin `p` (p = 0..3 for pins A..D) is at `0x00 + 4*s + p`. Channel `c` target is at `0x20 + c`, and channel `c` sensitivity (bit 0, 1 = level) is at `0x30 + c`. Motherboard source `m` target is at `0x40 + m`, and its enable (bit 0) is at `0x50 + m`. Parameters must keep slot entries below 0x20 and channel and source counts at 16 or fewer.

Top module: `irq_steer_router`

## Requirements
- R1: After reset, all routing entries read 0x00, every channel and motherboard target reads 0x80, every channel sensitivity reads 0x01 (level), every motherboard enable reads 0x00, and both output vectors are zero; asserting `rst_n` low clears the outputs at once.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` on the next clock; sensitivity and enable registers keep bit 0 only and read back with bits 7:1 zero. An address outside the map reads 0xFF, and writing there changes no stored entry.
- R3: A slot pin whose routing entry is 0, or greater than the number of channels, contributes nothing to the outputs.
- R4: A slot pin (index 4*slot + pin in `pin_req`) with routing entry k (1..NUM_CHAN) drives the line held in channel k-1's target register.
- R5: A steered request's sensitivity is the channel's sensitivity bit, independent of which slot or pin requested.
- R6: A motherboard source whose enable is 0 is ignored; an enabled one drives its target line with the sensitivity given on its `src_lvl` bit.
- R7: Direct request i drives line (i mod 16) and never marks that line level-sensitive.
- R8: A channel or motherboard source whose target is above 15 drives no line.
- R9: Each output line is the OR of all requests that resolve to it; its level bit is set when at least one of those requests is level-sensitive.
- R10: Outputs follow the requests with exactly one clock of latency, and a level bit is never set without its request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back data for `cfg_addr` (combinational) |
| pin_req | input | NUM_SLOTS*4 | Slot pin requests, bit 4*slot+pin |
| src_req | input | NUM_SRC | Motherboard source requests |
| src_lvl | input | NUM_SRC | Sensitivity supplied by each motherboard source (1 = level) |
| dir_req | input | NUM_DIRECT | Direct line requests |
| irq_req | output | 16 | Registered requested-line vector |
| irq_lvl | output | 16 | Registered level-sensitivity vector |

## Verification
The bench builds the router with its defaults: four slots, four channels, two motherboard sources and twenty direct inputs. With twenty direct inputs, indices 16 to 19 wrap to lines 0 to 3, so the modulo rule is exercised. Four channels leave routing value 7 out of range, which tests the drop rule. Two channels pointed at one line and a motherboard source sharing a line with an edge channel make the OR and the level merge visible at the ports.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned IRQ_LINES = 16;
  localparam int unsigned PINS_PER_SLOT = 4;

  typedef logic [7:0] byte_t;

  localparam byte_t ADDR_ROUTE     = 8'h00;
  localparam byte_t ADDR_CHAN_IRQ  = 8'h20;
  localparam byte_t ADDR_CHAN_MODE = 8'h30;
  localparam byte_t ADDR_SRC_IRQ   = 8'h40;
  localparam byte_t ADDR_SRC_EN    = 8'h50;
  localparam byte_t IRQ_OFF        = 8'h80;
  localparam byte_t RD_NONE        = 8'hFF;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/irq_cfg_file.sv
module irq_cfg_file
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_CHAN  = 4,
  parameter int unsigned NUM_SRC   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  byte_t                             cfg_addr,
  input  byte_t                             cfg_wdata,
  output byte_t                             cfg_rdata,
  output logic [NUM_SLOTS*PINS_PER_SLOT-1:0][7:0] route_o,
  output logic [NUM_CHAN-1:0][7:0]          chan_irq_o,
  output logic [NUM_CHAN-1:0]               chan_lvl_o,
  output logic [NUM_SRC-1:0][7:0]           src_irq_o,
  output logic [NUM_SRC-1:0]                src_en_o
);
  localparam int unsigned NPIN = NUM_SLOTS * PINS_PER_SLOT;

  logic [NPIN-1:0][7:0]     route_q, route_d;
  logic [NUM_CHAN-1:0][7:0] chan_irq_q, chan_irq_d;
  logic [NUM_CHAN-1:0]      chan_lvl_q, chan_lvl_d;
  logic [NUM_SRC-1:0][7:0]  src_irq_q, src_irq_d;
  logic [NUM_SRC-1:0]       src_en_q, src_en_d;

  // Next-state: one decoded write per entry.
  always_comb begin
    route_d    = route_q;
    chan_irq_d = chan_irq_q;
    chan_lvl_d = chan_lvl_q;
    src_irq_d  = src_irq_q;
    src_en_d   = src_en_q;
    for (int i = 0; i < int'(NPIN); i++)
      if (cfg_addr == ADDR_ROUTE + 8'(i)) route_d[i] = cfg_wdata;
    for (int c = 0; c < int'(NUM_CHAN); c++) begin
      if (cfg_addr == ADDR_CHAN_IRQ + 8'(c))  chan_irq_d[c] = cfg_wdata;
      if (cfg_addr == ADDR_CHAN_MODE + 8'(c)) chan_lvl_d[c] = cfg_wdata[0];
    end
    for (int m = 0; m < int'(NUM_SRC); m++) begin
      if (cfg_addr == ADDR_SRC_IRQ + 8'(m)) src_irq_d[m] = cfg_wdata;
      if (cfg_addr == ADDR_SRC_EN + 8'(m))  src_en_d[m]  = cfg_wdata[0];
    end
  end

  // Registers, enabled by the write strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q    <= '0;
      chan_irq_q <= {NUM_CHAN{IRQ_OFF}};
      chan_lvl_q <= {NUM_CHAN{SENSE_LEVEL}};
      src_irq_q  <= {NUM_SRC{IRQ_OFF}};
      src_en_q   <= '0;
    end else if (cfg_we) begin
      route_q    <= route_d;
      chan_irq_q <= chan_irq_d;
      chan_lvl_q <= chan_lvl_d;
      src_irq_q  <= src_irq_d;
      src_en_q   <= src_en_d;
    end
  end

  // Read-back multiplexer.
  always_comb begin
    cfg_rdata = RD_NONE;
    for (int i = 0; i < int'(NPIN); i++)
      if (cfg_addr == ADDR_ROUTE + 8'(i)) cfg_rdata = route_q[i];
    for (int c = 0; c < int'(NUM_CHAN); c++) begin
      if (cfg_addr == ADDR_CHAN_IRQ + 8'(c))  cfg_rdata = chan_irq_q[c];
      if (cfg_addr == ADDR_CHAN_MODE + 8'(c)) cfg_rdata = {7'b0, chan_lvl_q[c]};
    end
    for (int m = 0; m < int'(NUM_SRC); m++) begin
      if (cfg_addr == ADDR_SRC_IRQ + 8'(m)) cfg_rdata = src_irq_q[m];
      if (cfg_addr == ADDR_SRC_EN + 8'(m))  cfg_rdata = {7'b0, src_en_q[m]};
    end
  end

  assign route_o    = route_q;
  assign chan_irq_o = chan_irq_q;
  assign chan_lvl_o = chan_lvl_q;
  assign src_irq_o  = src_irq_q;
  assign src_en_o   = src_en_q;

  // R2: without a strobe no table moves.
  p_tables_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(route_q) && $stable(chan_irq_q) && $stable(chan_lvl_q)
                 && $stable(src_irq_q) && $stable(src_en_q)));

  // R2: a write to channel 0 sensitivity lands on the next edge.
  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_CHAN_MODE) |=> (chan_lvl_q[0] == $past(cfg_wdata[0])));
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned NUM_CHAN   = 4,
  parameter int unsigned NUM_SRC    = 2,
  parameter int unsigned NUM_DIRECT = 20
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0][7:0] route_i,
  input  logic [NUM_CHAN-1:0][7:0]          chan_irq_i,
  input  logic [NUM_CHAN-1:0]               chan_lvl_i,
  input  logic [NUM_SRC-1:0][7:0]           src_irq_i,
  input  logic [NUM_SRC-1:0]                src_en_i,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_req_i,
  input  logic [NUM_SRC-1:0]                src_req_i,
  input  logic [NUM_SRC-1:0]                src_lvl_i,
  input  logic [NUM_DIRECT-1:0]             dir_req_i,
  output logic [IRQ_LINES-1:0]              hit_o,
  output logic [IRQ_LINES-1:0]              lvl_o
);
  localparam int unsigned NPIN = NUM_SLOTS * PINS_PER_SLOT;

  always_comb begin
    hit_o = '0;
    lvl_o = '0;
    // Steered slot pins: sensitivity always from the channel.
    for (int i = 0; i < int'(NPIN); i++) begin
      for (int c = 0; c < int'(NUM_CHAN); c++) begin
        if (pin_req_i[i] && (route_i[i] == 8'(c + 1)) && (chan_irq_i[c][7:4] == 4'h0)) begin
          hit_o[chan_irq_i[c][3:0]] = 1'b1;
          if (chan_lvl_i[c]) lvl_o[chan_irq_i[c][3:0]] = 1'b1;
        end
      end
    end
    // Motherboard sources: gated by enable, sensitivity from requester.
    for (int m = 0; m < int'(NUM_SRC); m++) begin
      if (src_req_i[m] && src_en_i[m] && (src_irq_i[m][7:4] == 4'h0)) begin
        hit_o[src_irq_i[m][3:0]] = 1'b1;
        if (src_lvl_i[m]) lvl_o[src_irq_i[m][3:0]] = 1'b1;
      end
    end
    // Direct lines: low four bits of the index, edge only.
    for (int d = 0; d < int'(NUM_DIRECT); d++)
      if (dir_req_i[d]) hit_o[d % int'(IRQ_LINES)] = 1'b1;
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LINES-1:0] hit_i,
  input  logic [IRQ_LINES-1:0] lvl_i,
  output logic [IRQ_LINES-1:0] irq_req_o,
  output logic [IRQ_LINES-1:0] irq_lvl_o
);
  logic [IRQ_LINES-1:0] req_q, req_d;
  logic [IRQ_LINES-1:0] lvl_q, lvl_d;

  always_comb begin
    req_d = hit_i;
    lvl_d = lvl_i & hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_req_o = req_q;
  assign irq_lvl_o = lvl_q;

  // R10: a level mark only ever accompanies a request.
  p_lvl_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_lvl_o & ~irq_req_o) == '0));
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned NUM_CHAN   = 4,
  parameter int unsigned NUM_SRC    = 2,
  parameter int unsigned NUM_DIRECT = 20
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [7:0]                         cfg_addr,
  input  logic [7:0]                         cfg_wdata,
  output logic [7:0]                         cfg_rdata,
  input  logic [NUM_SLOTS*4-1:0]             pin_req,
  input  logic [NUM_SRC-1:0]                 src_req,
  input  logic [NUM_SRC-1:0]                 src_lvl,
  input  logic [NUM_DIRECT-1:0]              dir_req,
  output logic [15:0]                        irq_req,
  output logic [15:0]                        irq_lvl
);
  localparam int unsigned NPIN = NUM_SLOTS * PINS_PER_SLOT;

  // Reset: asserts asynchronously, releases on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NPIN-1:0][7:0]     route_w;
  logic [NUM_CHAN-1:0][7:0] chan_irq_w;
  logic [NUM_CHAN-1:0]      chan_lvl_w;
  logic [NUM_SRC-1:0][7:0]  src_irq_w;
  logic [NUM_SRC-1:0]       src_en_w;
  logic [IRQ_LINES-1:0]     hit_w, lvl_w;

  irq_cfg_file #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CHAN(NUM_CHAN), .NUM_SRC(NUM_SRC)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .route_o    (route_w),
    .chan_irq_o (chan_irq_w),
    .chan_lvl_o (chan_lvl_w),
    .src_irq_o  (src_irq_w),
    .src_en_o   (src_en_w)
  );

  irq_route_decode #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CHAN(NUM_CHAN),
    .NUM_SRC(NUM_SRC), .NUM_DIRECT(NUM_DIRECT)
  ) u_dec (
    .route_i    (route_w),
    .chan_irq_i (chan_irq_w),
    .chan_lvl_i (chan_lvl_w),
    .src_irq_i  (src_irq_w),
    .src_en_i   (src_en_w),
    .pin_req_i  (pin_req),
    .src_req_i  (src_req),
    .src_lvl_i  (src_lvl),
    .dir_req_i  (dir_req),
    .hit_o      (hit_w),
    .lvl_o      (lvl_w)
  );

  irq_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .hit_i     (hit_w),
    .lvl_i     (lvl_w),
    .irq_req_o (irq_req),
    .irq_lvl_o (irq_lvl)
  );

  // R10: with no request of any kind, nothing is asserted next cycle.
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pin_req == '0 && src_req == '0 && dir_req == '0) |=> (irq_req == '0));

  // R7: direct requests alone never mark a line level-sensitive.
  p_direct_edge_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pin_req == '0 && src_req == '0) |=> (irq_lvl == '0));

  // R6: requests only from disabled motherboard sources produce nothing.
  p_src_disabled_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pin_req == '0 && dir_req == '0 && (src_req & src_en_w) == '0) |=> (irq_req == '0));
endmodule

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;
  localparam int NS = 4, NC = 4, NM = 2, ND = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [NS*4-1:0] pin_req = '0;
  logic [NM-1:0] src_req = '0, src_lvl = '0;
  logic [ND-1:0] dir_req = '0;
  logic [15:0] irq_req, irq_lvl;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_steer_router #(.NUM_SLOTS(NS), .NUM_CHAN(NC), .NUM_SRC(NM), .NUM_DIRECT(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_req(pin_req),
    .src_req(src_req), .src_lvl(src_lvl), .dir_req(dir_req),
    .irq_req(irq_req), .irq_lvl(irq_lvl)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a; #1;
    chk(tag, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_reqs();
    pin_req = '0; src_req = '0; src_lvl = '0; dir_req = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; #1;
    chk("R1 async clear req", irq_req, 16'h0);
    chk("R1 async clear lvl", irq_lvl, 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_values();
    for (int i = 0; i < NS*4; i++) rd_chk("R1 route", 8'(i), 8'h00);
    for (int c = 0; c < NC; c++) begin
      rd_chk("R1 chan target", 8'h20 + 8'(c), 8'h80);
      rd_chk("R1 chan mode", 8'h30 + 8'(c), 8'h01);
    end
    for (int m = 0; m < NM; m++) begin
      rd_chk("R1 src target", 8'h40 + 8'(m), 8'h80);
      rd_chk("R1 src enable", 8'h50 + 8'(m), 8'h00);
    end
    chk("R1 req idle", irq_req, 16'h0);
    chk("R1 lvl idle", irq_lvl, 16'h0);
  endtask

  task automatic t_regs();
    rd_chk("R2 unmapped read", 8'h60, 8'hFF);
    rd_chk("R2 unmapped read gap", 8'h24, 8'hFF);
    wr(8'h60, 8'h33);
    rd_chk("R2 unmapped write ignored", 8'h60, 8'hFF);
    rd_chk("R2 unmapped write route0", 8'h00, 8'h00);
    wr(8'h31, 8'hFE);
    rd_chk("R2 mode bit0 only", 8'h31, 8'h00);
    wr(8'h20, 8'h05);
    rd_chk("R2 target readback", 8'h20, 8'h05);
  endtask

  task automatic t_setup();
    wr(8'h20, 8'h05);  // chan0 -> 5, level
    wr(8'h21, 8'h09);  // chan1 -> 9
    wr(8'h31, 8'h00);  // chan1 edge
    wr(8'h22, 8'h05);  // chan2 -> 5, level
    wr(8'h00, 8'h01);  // slot0 pin A -> chan0
    wr(8'h05, 8'h02);  // slot1 pin B -> chan1
    wr(8'h0A, 8'h03);  // slot2 pin C -> chan2
    wr(8'h0F, 8'h04);  // slot3 pin D -> chan3 (target 0x80)
    wr(8'h04, 8'h07);  // slot1 pin A -> out of range
    rd_chk("R2 route readback", 8'h05, 8'h02);
  endtask

  task automatic t_unrouted();
    clear_reqs(); pin_req[1] = 1'b1; step();
    chk("R3 route 0 dropped", irq_req, 16'h0);
    clear_reqs(); pin_req[4] = 1'b1; step();
    chk("R3 route beyond channels dropped", irq_req, 16'h0);
    clear_reqs(); step();
  endtask

  task automatic t_steer();
    clear_reqs(); pin_req[0] = 1'b1; #1;
    chk("R10 no change before edge", irq_req, 16'h0);
    step();
    chk("R4 slot0A to line5", irq_req, 16'h0020);
    chk("R5 chan0 level", irq_lvl, 16'h0020);
    clear_reqs(); pin_req[5] = 1'b1; step();
    chk("R4 slot1B to line9", irq_req, 16'h0200);
    chk("R5 chan1 edge", irq_lvl, 16'h0000);
    clear_reqs(); step();
    chk("R10 released", irq_req, 16'h0);
  endtask

  task automatic t_offrange();
    clear_reqs(); pin_req[15] = 1'b1; step();
    chk("R8 marker target silent", irq_req, 16'h0);
    wr(8'h23, 8'h10);
    step();
    chk("R8 target 16 silent", irq_req, 16'h0);
    wr(8'h23, 8'h0F);
    step();
    chk("R8 target 15 ok", irq_req, 16'h8000);
    clear_reqs(); step();
  endtask

  task automatic t_merge();
    clear_reqs(); pin_req[0] = 1'b1; pin_req[10] = 1'b1; step();
    chk("R9 two chans one line", irq_req, 16'h0020);
    pin_req[0] = 1'b0; step();
    chk("R9 line held by other", irq_req, 16'h0020);
    pin_req[5] = 1'b1; step();
    chk("R9 two lines", irq_req, 16'h0220);
    chk("R9 lvl only line5", irq_lvl, 16'h0020);
    clear_reqs(); step();
  endtask

  task automatic t_mb();
    wr(8'h40, 8'h03);
    clear_reqs(); src_req[0] = 1'b1; src_lvl[0] = 1'b1; step();
    chk("R6 disabled ignored", irq_req, 16'h0);
    wr(8'h50, 8'h01);
    step();
    chk("R6 enabled req", irq_req, 16'h0008);
    chk("R6 requester level", irq_lvl, 16'h0008);
    src_lvl[0] = 1'b0; step();
    chk("R6 requester edge", irq_lvl, 16'h0000);
    wr(8'h51, 8'h01);
    clear_reqs(); src_req[1] = 1'b1; step();
    chk("R8 src marker silent", irq_req, 16'h0);
    wr(8'h41, 8'h09);
    src_lvl[1] = 1'b1; pin_req[5] = 1'b1; step();
    chk("R9 edge chan+level src", irq_req, 16'h0200);
    chk("R9 lvl merged", irq_lvl, 16'h0200);
    clear_reqs(); step();
  endtask

  task automatic t_direct();
    clear_reqs(); dir_req[6] = 1'b1; step();
    chk("R7 direct line6", irq_req, 16'h0040);
    chk("R7 direct edge", irq_lvl, 16'h0);
    clear_reqs(); dir_req[18] = 1'b1; step();
    chk("R7 direct wraps to 2", irq_req, 16'h0004);
    clear_reqs(); dir_req[5] = 1'b1; pin_req[5] = 1'b1; step();
    chk("R9 direct+chan", irq_req, 16'h0220);
    clear_reqs(); step();
  endtask

  task automatic t_rereset();
    dir_req[3] = 1'b1; step();
    chk("R7 pre-reset", irq_req, 16'h0008);
    do_reset();
    clear_reqs(); step();
    rd_chk("R1 route cleared", 8'h00, 8'h00);
    rd_chk("R1 chan target restored", 8'h21, 8'h80);
    rd_chk("R1 chan mode restored", 8'h31, 8'h01);
    rd_chk("R1 src enable cleared", 8'h50, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 in reset req", irq_req, 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_values();
    t_regs();
    t_setup();
    t_unrouted();
    t_steer();
    t_offrange();
    t_merge();
    t_mb();
    t_direct();
    t_rereset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule